// File: doc/BRIEF.md
# Selectable-Reference Digital Phase Detector

This block is the measuring front end of a digital phase-locked loop. A reference input, which may run at a low frame rate (8 kHz) or at one of two line rates (1.544 MHz or 2.048 MHz), is brought into the local sampling clock domain. Its falling edges are compared against a feedback phase made by dividing the sampling clock. Each comparison yields a signed error, counted in sampling-clock cycles from the reference edge to the nearest feedback edge, together with a one-cycle valid strobe. A loop filter downstream consumes the samples.

A two-bit select code picks the reference rate and, with it, the feedback division. The code is captured at the first clock after reset and governs the block from then on. One code value is reserved and flagged as invalid. A later change of the code is flagged as needing a fresh reset. After reset the feedback phase snaps to the first reference falling edge, so measurement starts from zero error. When the reference stops, a loss flag is raised and no samples are produced.

Top module: `refsel_phase_det`

## Requirements
- R1: The select code captured on the first clock after reset release sets the feedback period in sampling clocks: 2'b01 gives P_LOW (8 kHz reference), 2'b10 gives P_T1 (1.544 MHz) and 2'b11 gives P_E1 (2.048 MHz). Errors wrap modulo that period.
- R2: Code 2'b00 is reserved. sel_bad_o is high from the clock edge after 2'b00 is present on sel_i, and also while 2'b00 is the captured code. No valid_o pulse is produced while it is applied.
- R3: Only falling edges of ref_i are compared. Rising edges and steady levels produce no sample.
- R4: rst_req_o rises on the clock edge after sel_i differs from the captured code. It stays high until rst_n is driven low. Until then the captured code keeps setting the period.
- R5: rst_n is asynchronous and active low. While it is low, err_o, valid_o, lor_o, sel_bad_o and rst_req_o are all zero. The first falling edge of ref_i after release marks feedback phase zero and produces no sample.
- R6: Let c be the number of clock cycles from the aligning edge to the current falling edge, taken modulo the period P. Then err_o = c when c <= floor(P/2), otherwise err_o = c - P, bounded to plus or minus floor(P/2). A falling edge first sampled by the clock at edge A gives valid_o and err_o after edge A+2.
- R7: valid_o is high for exactly one cycle per sample. err_o holds its value between samples.
- R8: When 2P clock cycles pass after a falling edge without another one, lor_o rises. The next falling edge clears lor_o and produces no sample. A spacing of exactly 2P cycles still produces a normal sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling (local oscillator) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 2 | Reference rate select code |
| ref_i | input | 1 | Asynchronous reference input |
| err_o | output | ERR_W | Signed phase error in clock cycles |
| valid_o | output | 1 | One-cycle strobe marking a new err_o |
| lor_o | output | 1 | Reference lost |
| sel_bad_o | output | 1 | Reserved select code applied |
| rst_req_o | output | 1 | Select changed since reset |

## Verification
The bench aims at the wrap point of the error mapping: exactly half a period must stay positive and one cycle more must turn negative. A detector that rounds the wrong way would flip the sign of the error exactly at the loop's widest excursion. It also accumulates phase across many edges at all three rates. A feedback counter that restarted on each edge, or divided by the wrong period, would then report small constant errors instead of the wrapped running phase. Further cases probe the loss window at exactly twice the period and the edge that ends a loss, where an off-by-one would either drop a good sample or pass a garbage one. The last cases change the select code without a reset, which must raise the flag yet leave the old division in force, and hold the reserved code, which must stay silent.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

   typedef enum logic [1:0] {
      SEL_RSVD = 2'b00,
      SEL_LOW  = 2'b01,
      SEL_T1   = 2'b10,
      SEL_E1   = 2'b11
   } refsel_code_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/refsel_sel_decode.sv
module refsel_sel_decode
   import refsel_pkg::*;
#(
   parameter int P_LOW = 2500,
   parameter int P_T1  = 13,
   parameter int P_E1  = 10,
   parameter int CW    = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    sel_i,
   output logic [CW-1:0] period_o,
   output logic          code_ok_o,
   output logic          sel_bad_o,
   output logic          rst_req_o
);

   logic         cap_v_q;
   refsel_code_e sel_cap_q;
   refsel_code_e sel_now;

   assign sel_now = refsel_code_e'(sel_i);

   // capture once after reset, then watch for changes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_v_q   <= 1'b0;
         sel_cap_q <= SEL_RSVD;
         sel_bad_o <= 1'b0;
         rst_req_o <= 1'b0;
      end else begin
         if (!cap_v_q) begin
            cap_v_q   <= 1'b1;
            sel_cap_q <= sel_now;
         end
         rst_req_o <= rst_req_o | (cap_v_q && (sel_now != sel_cap_q));
         sel_bad_o <= (sel_now == SEL_RSVD) | (cap_v_q && (sel_cap_q == SEL_RSVD));
      end
   end

   always_comb begin
      unique case (sel_cap_q)
         SEL_LOW:  period_o = CW'(P_LOW);
         SEL_T1:   period_o = CW'(P_T1);
         SEL_E1:   period_o = CW'(P_E1);
         default:  period_o = CW'(P_LOW);
      endcase
   end

   assign code_ok_o = cap_v_q && (sel_cap_q != SEL_RSVD);

endmodule

// File: rtl/refsel_fall_detect.sv
module refsel_fall_detect #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_i,
   output logic fall_o
);

   logic [STAGES:0] sh;

   // synchroniser chain plus one history flop
   for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[g] <= 1'b0;
            else        sh[g] <= ref_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh[g] <= 1'b0;
            else        sh[g] <= sh[g-1];
         end
      end
   end

   assign fall_o = sh[STAGES] & ~sh[STAGES-1];

endmodule

// File: rtl/refsel_fb_divider.sv
module refsel_fb_divider #(
   parameter int CW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          fall_i,
   input  logic [CW-1:0] period_i,
   output logic [CW-1:0] cnt_o,
   output logic          aligned_o
);

   logic [CW-1:0] last_phase;
   assign last_phase = period_i - CW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         aligned_o <= 1'b0;
         cnt_o     <= '0;
      end else if (en_i) begin
         if (!aligned_o) begin
            if (fall_i) begin
               aligned_o <= 1'b1;
               cnt_o     <= CW'(1);
            end
         end else if (cnt_o >= last_phase) begin
            cnt_o <= '0;
         end else begin
            cnt_o <= cnt_o + CW'(1);
         end
      end
   end

endmodule

// File: rtl/refsel_err_count.sv
module refsel_err_count #(
   parameter int CW = 12,
   parameter int EW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en_i,
   input  logic                 fall_i,
   input  logic                 aligned_i,
   input  logic [CW-1:0]        cnt_i,
   input  logic [CW-1:0]        period_i,
   output logic signed [EW-1:0] err_o,
   output logic                 valid_o,
   output logic                 lor_o
);

   logic [CW:0]          lcnt_q;
   logic [CW:0]          lim;
   logic                 lost;
   logic                 take;
   logic signed [EW-1:0] c_s, p_s, h_s, raw, sat;

   assign lim  = {period_i, 1'b0};
   assign lost = en_i && (lcnt_q >= lim);
   assign take = fall_i & aligned_i & en_i & ~lost;

   assign c_s = EW'(cnt_i);
   assign p_s = EW'(period_i);
   assign h_s = EW'(period_i >> 1);
   assign raw = (c_s <= h_s) ? c_s : (c_s - p_s);

   always_comb begin
      if (raw > h_s)       sat = h_s;
      else if (raw < -h_s) sat = -h_s;
      else                 sat = raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lcnt_q  <= '0;
         valid_o <= 1'b0;
         err_o   <= '0;
      end else begin
         valid_o <= take;
         if (take) err_o <= sat;
         if (!en_i || fall_i) lcnt_q <= '0;
         else if (!lost)      lcnt_q <= lcnt_q + 1'b1;
      end
   end

   assign lor_o = lost;

endmodule

// File: rtl/refsel_phase_det.sv
module refsel_phase_det
   import refsel_pkg::*;
#(
   parameter int P_LOW       = 2500,
   parameter int P_T1        = 13,
   parameter int P_E1        = 10,
   parameter int SYNC_STAGES = 2,
   parameter int ERR_W       = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [1:0]              sel_i,
   input  logic                    ref_i,
   output logic signed [ERR_W-1:0] err_o,
   output logic                    valid_o,
   output logic                    lor_o,
   output logic                    sel_bad_o,
   output logic                    rst_req_o
);

   localparam int P_MAX = max3(P_LOW, P_T1, P_E1);
   localparam int CW    = $clog2(P_MAX + 1);

   if (P_LOW < 4 || P_T1 < 4 || P_E1 < 4) begin : g_chk_period
      $error("feedback periods must be at least 4 clocks");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("synchroniser needs at least two stages");
   end
   if (ERR_W < CW + 1) begin : g_chk_width
      $error("error width too small for the longest period");
   end

   logic [CW-1:0] op_period;
   logic          code_ok;
   logic          ref_fall;
   logic          fb_aligned;
   logic [CW-1:0] fb_cnt;
   logic          meas_en;

   refsel_sel_decode #(
      .P_LOW(P_LOW), .P_T1(P_T1), .P_E1(P_E1), .CW(CW)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
      .period_o(op_period), .code_ok_o(code_ok),
      .sel_bad_o(sel_bad_o), .rst_req_o(rst_req_o)
   );

   refsel_fall_detect #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .fall_o(ref_fall)
   );

   refsel_fb_divider #(.CW(CW)) u_fb (
      .clk(clk), .rst_n(rst_n), .en_i(code_ok), .fall_i(ref_fall),
      .period_i(op_period), .cnt_o(fb_cnt), .aligned_o(fb_aligned)
   );

   assign meas_en = code_ok & ~sel_bad_o;

   refsel_err_count #(.CW(CW), .EW(ERR_W)) u_err (
      .clk(clk), .rst_n(rst_n), .en_i(meas_en), .fall_i(ref_fall),
      .aligned_i(fb_aligned), .cnt_i(fb_cnt), .period_i(op_period),
      .err_o(err_o), .valid_o(valid_o), .lor_o(lor_o)
   );

endmodule

// File: rtl/refsel_phase_det_chk.sv
module refsel_phase_det_chk #(
   parameter int CW = 12,
   parameter int EW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic signed [EW-1:0] err_o,
   input logic                 valid_o,
   input logic                 lor_o,
   input logic                 sel_bad_o,
   input logic                 rst_req_o,
   input logic                 aligned_i,
   input logic [CW-1:0]        period_i
);

   logic signed [EW-1:0] half_s;
   assign half_s = EW'(period_i >> 1);

   // R7
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R2
   no_sample_bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_bad_o |=> !valid_o);

   // R8
   no_sample_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lor_o |=> !valid_o);

   // R4
   reset_req_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> rst_req_o);

   // R5
   no_sample_unaligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !aligned_i |=> !valid_o);

   // R6
   err_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (err_o <= half_s && err_o >= -half_s));

endmodule

bind refsel_phase_det refsel_phase_det_chk #(.CW(CW), .EW(ERR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .err_o(err_o), .valid_o(valid_o),
   .lor_o(lor_o), .sel_bad_o(sel_bad_o), .rst_req_o(rst_req_o),
   .aligned_i(fb_aligned), .period_i(op_period)
);

// File: tb/refsel_phase_det_test.sv
module refsel_phase_det_test;

   localparam int CLK_PERIOD = 10;
   localparam int P_LOW = 2500;
   localparam int P_T1  = 13;
   localparam int P_E1  = 10;
   localparam int NV    = 17;

   // {select code, cycles since previous falling edge, expected error}
   localparam int TBL [NV][3] = '{
      '{3, 10, 0}, '{3, 13, 3}, '{3, 12, 5}, '{3, 11, -4}, '{3, 20, -4}, '{3, 14, 0},
      '{2, 13, 0}, '{2, 19, 6}, '{2, 14, -6}, '{2, 25, 6}, '{2, 8, 1},
      '{1, 2500, 0}, '{1, 2503, 3}, '{1, 2497, 0}, '{1, 1250, 1250},
      '{1, 2000, 750}, '{1, 1000, -750}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] sel = 2'b11;
   logic ref_in = 1'b0;
   logic signed [15:0] err;
   logic valid, lor, bad, req;

   refsel_phase_det uut (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .ref_i(ref_in),
      .err_o(err), .valid_o(valid), .lor_o(lor),
      .sel_bad_o(bad), .rst_req_o(req)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int errors = 0, checks = 0, nsamp = 0, pushed = 0;
   int exp_q[$];
   int acc = 0, per = 10;
   logic lor_seen = 1'b0;
   int popped;

   task automatic chk(input bit ok, input string rq, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", rq, act, expv);
      end
   endtask

   // every sample is compared with the oldest expectation
   always @(negedge clk) begin
      if (rst_n && valid) begin
         nsamp++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2 R3 R5 R8 sample where none is due", int'(err), 0);
         end else begin
            popped = exp_q.pop_front();
            chk(int'(err) == popped, "R1 R6 error value", int'(err), popped);
         end
      end
   end

   function automatic int period_of(input int s);
      case (s)
         1: return P_LOW;
         2: return P_T1;
         3: return P_E1;
         default: return 1;
      endcase
   endfunction

   function automatic int wrap(input int a, input int p);
      int c;
      c = a % p;
      return (c <= p / 2) ? c : c - p;
   endfunction

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
      acc = (acc + n) % per;
   endtask

   task automatic pulse(input int d, input bit smp);
      for (int i = 1; i <= d; i++) begin
         @(negedge clk);
         if (i == 2) ref_in = 1'b1;
         if (i == d) begin
            lor_seen = lor;
            ref_in = 1'b0;
         end
      end
      acc = (acc + d) % per;
      if (smp) begin
         exp_q.push_back(wrap(acc, per));
         pushed++;
      end
   endtask

   task automatic do_reset(input int s);
      @(negedge clk);
      rst_n = 1'b0;
      ref_in = 1'b0;
      sel = s[1:0];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      per = period_of(s);
      acc = 0;
   endtask

   task automatic align();
      pulse(8, 1'b0);
      acc = 0;
   endtask

   task automatic drain();
      idle(4);
      chk(exp_q.size() == 0, "R6 all due samples delivered", exp_q.size(), 0);
      chk(nsamp == pushed, "R5 sample count (none at alignment)", nsamp, pushed);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      int cur;
      int n0;
      // R5 reset state
      repeat (2) @(negedge clk);
      chk(valid == 1'b0, "R5 valid in reset", valid, 0);
      chk(err == 0, "R5 err in reset", int'(err), 0);
      chk(lor == 1'b0, "R5 lor in reset", lor, 0);
      chk(req == 1'b0 && bad == 1'b0, "R5 flags in reset", {req, bad}, 0);

      // table of rate groups, each after reset and alignment (R1, R6)
      cur = -1;
      for (int r = 0; r < NV; r++) begin
         if (TBL[r][0] != cur) begin
            if (cur != -1) drain();
            cur = TBL[r][0];
            do_reset(cur);
            align();
         end
         pulse(TBL[r][1], 1'b0);
         exp_q.push_back(TBL[r][2]);
         pushed++;
      end
      drain();

      // R6 latency and R7 single pulse
      do_reset(3);
      align();
      pulse(13, 1'b1);
      @(negedge clk);
      @(negedge clk);
      chk(valid == 1'b0, "R6 no sample before edge A+2", valid, 0);
      @(negedge clk);
      chk(valid == 1'b1, "R6 sample after edge A+2", valid, 1);
      @(negedge clk);
      chk(valid == 1'b0, "R7 strobe lasts one cycle", valid, 0);
      chk(err == 3, "R7 err holds", int'(err), 3);
      acc = (acc + 4) % per;

      // R3 rising edge alone gives nothing
      n0 = nsamp;
      @(negedge clk);
      ref_in = 1'b1;
      acc = (acc + 1) % per;
      idle(8);
      chk(nsamp == n0, "R3 rising edge ignored", nsamp, n0);
      pulse(6, 1'b1);

      // R8 boundary and loss
      pulse(20, 1'b1);
      chk(lor_seen == 1'b0, "R8 spacing 2P not lost", lor_seen, 0);
      pulse(30, 1'b0);
      chk(lor_seen == 1'b1, "R8 loss flagged", lor_seen, 1);
      idle(3);
      chk(lor == 1'b0, "R8 loss cleared by edge", lor, 0);
      pulse(10, 1'b1);
      drain();

      // R4 select change without reset
      @(negedge clk);
      sel = 2'b10;
      acc = (acc + 1) % per;
      idle(1);
      chk(req == 1'b1, "R4 reset request raised", req, 1);
      pulse(13, 1'b1);
      drain();
      chk(req == 1'b1, "R4 reset request held", req, 1);
      do_reset(2);
      @(negedge clk);
      chk(req == 1'b0, "R4 reset clears request", req, 0);

      // R2 reserved code applied while running
      align();
      pulse(13, 1'b1);
      drain();
      @(negedge clk);
      sel = 2'b00;
      acc = (acc + 1) % per;
      idle(1);
      chk(bad == 1'b1, "R2 reserved code flagged", bad, 1);
      n0 = nsamp;
      pulse(9, 1'b0);
      pulse(9, 1'b0);
      idle(4);
      chk(nsamp == n0, "R2 no samples on reserved code", nsamp, n0);

      // R2 reserved code captured at reset
      do_reset(0);
      @(negedge clk);
      chk(bad == 1'b1, "R2 reserved code after reset", bad, 1);
      pulse(8, 1'b0);
      pulse(8, 1'b0);
      pulse(8, 1'b0);
      idle(4);
      chk(nsamp == n0, "R2 silent with reserved capture", nsamp, n0);
      chk(lor == 1'b0, "R2 no loss flag on reserved code", lor, 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule